// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a mobile SDRAM. After reset it owns the command bus and takes the memory through its mandatory start-up sequence. It holds clock enable and the data mask high and issues only NOP during a stabilization interval. It then precharges every bank, runs two auto-refresh cycles, writes the mode register and, unless told to skip it, writes the extended mode register. Each command is followed by a fixed minimum number of NOP cycles. When the last wait has expired it raises `init_done`, and the normal traffic scheduler may then take the bus.

All waits are parameters in clock cycles. The stabilization interval is `CLK_MHZ * STABLE_US` cycles. The mode register word is built from four parameters: burst length, burst type, CAS latency and write-burst mode. An illegal CAS latency or burst length raises `cfg_err`. In that case the sequencer never leaves the stabilization wait, so a reserved code never reaches the memory.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: From reset onward `cke` and `dqm` are high and `cs_n` is low. While reset is held, the command lines show NOP (`{ras_n,cas_n,we_n}` = 111) and `init_done` is low.
- R2: After reset is released, the bus carries only NOP for `CLK_MHZ*STABLE_US` cycles. The first command appears in cycle `CLK_MHZ*STABLE_US`, counting the first rising edge with reset released as cycle 1.
- R3: The first command is PRECHARGE ALL: encoding 010, `addr[10]` = 1, every other address bit 0, `ba` = 0. The next command follows exactly `T_RP` cycles later, with only NOP in between.
- R4: Exactly two AUTO REFRESH commands (encoding 001, `ba` and `addr` zero) follow. Each is followed by exactly `T_RC` cycles before the next command.
- R5: The mode register is written by MODE REGISTER SET (encoding 000) with `ba` = 00. Its address word has the burst-length code log2(`BURST_LEN`) in `addr[2:0]` and the burst type in `addr[3]` (1 = interleaved). It carries the CAS latency code in `addr[6:4]` and the write mode in `addr[9]` (1 = single write); every other bit is 0.
- R6: With `skip_emr` low, a second MODE REGISTER SET with `ba` = 10 and `addr` = `EMR_CFG` follows the mode register write by exactly `T_MRD` cycles. With `skip_emr` high, no further command is issued.
- R7: `init_done` rises exactly `T_MRD` cycles after the last MODE REGISTER SET and stays high until reset. While it is high, only NOP is driven.
- R8: If `CAS_LAT` is not 2 or 3, or `BURST_LEN` is not 1, 2, 4 or 8, `cfg_err` is high, only NOP is ever driven and `init_done` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| skip_emr | input | 1 | High: leave the extended mode register at its defaults |
| cke | output | 1 | Clock enable to the memory |
| dqm | output | 1 | Data mask to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address lines |
| init_done | output | 1 | Sequence complete |
| cfg_err | output | 1 | Illegal mode-register parameter |

## Verification
Every command output is registered. A command is therefore visible in the cycle numbered by the rising edge that issued it. Precharge is due in cycle S = `CLK_MHZ*STABLE_US`, the refreshes at S+T_RP and S+T_RP+T_RC, and the mode register write at S+T_RP+2*T_RC. The extended write follows T_MRD later, and `init_done` follows T_MRD after the last write. The driver computes these cycle numbers and queues them with the expected encoding, bank and address. The monitor samples on the falling clock edge against a cycle counter started at reset release, so each command is compared in exactly the cycle it is due. `init_done` is checked one cycle before and in its due cycle.

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq #(
  parameter int CLK_MHZ = 100,
  parameter int STABLE_US = 200,
  parameter int T_RP = 3,
  parameter int T_RC = 8,
  parameter int T_MRD = 2,
  parameter int BURST_LEN = 4,
  parameter int BURST_INTERLEAVED = 0,
  parameter int CAS_LAT = 3,
  parameter int SINGLE_WRITE = 0,
  parameter int ADDR_W = 13,
  parameter int BA_W = 2,
  parameter logic [ADDR_W-1:0] EMR_CFG = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              skip_emr,
  output logic              cke,
  output logic              dqm,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done,
  output logic              cfg_err
);
  localparam int STAB_CYC = CLK_MHZ * STABLE_US;
  localparam int CNT_W = $clog2(STAB_CYC + T_RP + T_RC + T_MRD + 1);
  localparam bit CL_OK = (CAS_LAT == 2) || (CAS_LAT == 3);
  localparam bit BL_OK = (BURST_LEN == 1) || (BURST_LEN == 2) || (BURST_LEN == 4) || (BURST_LEN == 8);
  localparam bit CFG_BAD = !(CL_OK && BL_OK);
  localparam logic [2:0] BL_CODE = (BURST_LEN == 1) ? 3'd0 : (BURST_LEN == 2) ? 3'd1 :
                                   (BURST_LEN == 4) ? 3'd2 : 3'd3;
  localparam logic [2:0] CL_CODE = (CAS_LAT == 3) ? 3'd3 : 3'd2;
  localparam logic [12:0] MR_BITS = {3'b000, SINGLE_WRITE[0], 2'b00, CL_CODE,
                                     BURST_INTERLEAVED[0], BL_CODE};
  localparam logic [ADDR_W-1:0] MR_WORD = ADDR_W'(MR_BITS);
  localparam logic [BA_W-1:0] MR_BA = '0;
  localparam logic [BA_W-1:0] EMR_BA = BA_W'(2'b10);

  localparam logic [2:0] CMD_NOP = 3'b111;
  localparam logic [2:0] CMD_PRE = 3'b010;
  localparam logic [2:0] CMD_REF = 3'b001;
  localparam logic [2:0] CMD_MRS = 3'b000;

  typedef enum logic [2:0] {ST_STAB, ST_PRE, ST_REF1, ST_REF2, ST_MR, ST_EMR, ST_DONE} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [2:0]        cmd;
  logic [BA_W-1:0]   ba_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_STAB;
      cnt    <= CNT_W'(STAB_CYC - 1);
      cmd    <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      cmd    <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        case (st)
          ST_STAB: if (!CFG_BAD) begin
            cmd        <= CMD_PRE;
            addr_q[10] <= 1'b1;
            st         <= ST_PRE;
            cnt        <= CNT_W'(T_RP - 1);
          end
          ST_PRE: begin
            cmd <= CMD_REF;
            st  <= ST_REF1;
            cnt <= CNT_W'(T_RC - 1);
          end
          ST_REF1: begin
            cmd <= CMD_REF;
            st  <= ST_REF2;
            cnt <= CNT_W'(T_RC - 1);
          end
          ST_REF2: begin
            cmd    <= CMD_MRS;
            ba_q   <= MR_BA;
            addr_q <= MR_WORD;
            st     <= ST_MR;
            cnt    <= CNT_W'(T_MRD - 1);
          end
          ST_MR: if (skip_emr) begin
            st     <= ST_DONE;
            done_q <= 1'b1;
          end else begin
            cmd    <= CMD_MRS;
            ba_q   <= EMR_BA;
            addr_q <= EMR_CFG;
            st     <= ST_EMR;
            cnt    <= CNT_W'(T_MRD - 1);
          end
          ST_EMR: begin
            st     <= ST_DONE;
            done_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign cke       = 1'b1;
  assign dqm       = 1'b1;
  assign cs_n      = 1'b0;
  assign {ras_n, cas_n, we_n} = cmd;
  assign ba        = ba_q;
  assign addr      = addr_q;
  assign init_done = done_q;
  assign cfg_err   = CFG_BAD;
endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk #(
  parameter int T_RP = 3,
  parameter int T_RC = 8,
  parameter int T_MRD = 2,
  parameter int ADDR_W = 13,
  parameter int BA_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              dqm,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done,
  input logic              cfg_err
);
  logic [2:0] cmd;
  logic [2:0] last;
  logic [7:0] gap;
  int         need;

  assign cmd = {ras_n, cas_n, we_n};

  always_comb begin
    case (last)
      3'b010:  need = T_RP;
      3'b001:  need = T_RC;
      3'b000:  need = T_MRD;
      default: need = 0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last <= 3'b111;
      gap  <= '0;
    end else if (cmd != 3'b111) begin
      last <= cmd;
      gap  <= 8'd1;
    end else if (gap != 8'hff) begin
      gap <= gap + 8'd1;
    end
  end

  // R1
  pins_high_chk: assert property (@(posedge clk) disable iff (!rst_n) cke && dqm && !cs_n);
  // R3
  pre_a10_chk: assert property (@(posedge clk) disable iff (!rst_n) (cmd == 3'b010) |-> addr[10]);
  // R3
  cmd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != 3'b111 && last != 3'b111) |-> (int'(gap) >= need));
  // R5
  mr_cl_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'b000 && ba == '0) |-> (addr[6:4] == 3'd2 || addr[6:4] == 3'd3));
  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) init_done |=> init_done);
  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) init_done |-> cmd == 3'b111);
  // R7
  done_after_mrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (last == 3'b000 && int'(gap) >= T_MRD));
  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (cmd == 3'b111 && !init_done));
endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(
  .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD), .ADDR_W(ADDR_W), .BA_W(BA_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .dqm(dqm), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done), .cfg_err(cfg_err)
);

// File: tb/test_sdram_pwrup_seq.sv
module test_sdram_pwrup_seq;
  localparam int CLK_MHZ = 100, STABLE_US = 200, T_RP = 3, T_RC = 8, T_MRD = 2;
  localparam int BURST_LEN = 4, BURST_INTERLEAVED = 1, CAS_LAT = 3, SINGLE_WRITE = 1;
  localparam logic [12:0] EMR_CFG = 13'h0020;
  localparam int S = CLK_MHZ * STABLE_US;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic skip_emr = 1'b0;
  logic cke, dqm, cs_n, ras_n, cas_n, we_n, init_done, cfg_err;
  logic [1:0] ba;
  logic [12:0] addr;
  logic e_cke, e_dqm, e_cs_n, e_ras_n, e_cas_n, e_we_n, e_done, e_err;
  logic [1:0] e_ba;
  logic [12:0] e_addr;

  int checks = 0, errors = 0, cyc = 0, done_cyc = 0;
  int err_cmds = 0;
  bit monitor_on = 1'b0;

  typedef struct { logic [2:0] cmd; logic [1:0] ba; logic [12:0] addr; int cyc; string req; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  sdram_pwrup_seq #(
    .CLK_MHZ(CLK_MHZ), .STABLE_US(STABLE_US), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD),
    .BURST_LEN(BURST_LEN), .BURST_INTERLEAVED(BURST_INTERLEAVED), .CAS_LAT(CAS_LAT),
    .SINGLE_WRITE(SINGLE_WRITE), .ADDR_W(13), .BA_W(2), .EMR_CFG(EMR_CFG)
  ) i_sdram_pwrup_seq (
    .clk(clk), .rst_n(rst_n), .skip_emr(skip_emr), .cke(cke), .dqm(dqm), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .init_done(init_done), .cfg_err(cfg_err)
  );

  sdram_pwrup_seq #(
    .CLK_MHZ(10), .STABLE_US(1), .CAS_LAT(4)
  ) i_bad_cfg (
    .clk(clk), .rst_n(rst_n), .skip_emr(1'b0), .cke(e_cke), .dqm(e_dqm), .cs_n(e_cs_n),
    .ras_n(e_ras_n), .cas_n(e_cas_n), .we_n(e_we_n), .ba(e_ba), .addr(e_addr),
    .init_done(e_done), .cfg_err(e_err)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] c, input logic [1:0] b, input logic [12:0] a, input int at, input string req);
    exp_t e;
    e.cmd = c; e.ba = b; e.addr = a; e.cyc = at; e.req = req;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (rst_n && monitor_on) begin
      if (!cke || !dqm || cs_n) check(1'b0, "R1", "cke/dqm/cs_n", {cke, dqm, cs_n}, 3'b110);
      if ({ras_n, cas_n, we_n} != 3'b111) begin
        if (q.size() == 0) begin
          check(1'b0, "R7", "stray command", {ras_n, cas_n, we_n}, 3'b111);
        end else begin
          exp_t e;
          e = q.pop_front();
          check({ras_n, cas_n, we_n} == e.cmd && ba == e.ba && addr == e.addr && cyc == e.cyc,
                e.req, "command {cmd,ba,addr,cycle}",
                {{ras_n, cas_n, we_n}, ba, addr, cyc[15:0]}, {e.cmd, e.ba, e.addr, e.cyc[15:0]});
        end
      end
      if (cyc == done_cyc - 1) check(init_done == 1'b0, "R7", "init_done early", init_done, 0);
      if (cyc == done_cyc) check(init_done == 1'b1, "R7", "init_done on time", init_done, 1);
      if ({e_ras_n, e_cas_n, e_we_n} != 3'b111 || e_done) err_cmds++;
    end
  end

  task automatic run(input bit skip);
    logic [12:0] mr;
    int t;
    @(negedge clk);
    rst_n = 1'b0;
    skip_emr = skip;
    monitor_on = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cke && dqm && !cs_n && {ras_n, cas_n, we_n} == 3'b111 && !init_done, "R1", "reset outputs",
          {cke, dqm, cs_n, ras_n, cas_n, we_n, init_done}, 7'b1101110);
    mr = 13'(($clog2(BURST_LEN)) | (BURST_INTERLEAVED << 3) | (CAS_LAT << 4) | (SINGLE_WRITE << 9));
    t = S;
    push(3'b010, 2'b00, 13'h0400, t, "R2/R3 precharge");
    t += T_RP;
    push(3'b001, 2'b00, 13'h0000, t, "R3/R4 refresh 1");
    t += T_RC;
    push(3'b001, 2'b00, 13'h0000, t, "R4 refresh 2");
    t += T_RC;
    push(3'b000, 2'b00, mr, t, "R4/R5 mode register");
    if (!skip) begin
      t += T_MRD;
      push(3'b000, 2'b10, EMR_CFG, t, "R6 extended mode register");
    end
    done_cyc = t + T_MRD;
    monitor_on = 1'b1;
    rst_n = 1'b1;
    while (cyc < done_cyc + 20) @(negedge clk);
    check(q.size() == 0, "R6", "commands left in queue", q.size(), 0);
    check(init_done == 1'b1, "R7", "init_done held", init_done, 1);
    q.delete();
  endtask

  initial begin
    run(1'b0);
    run(1'b1);
    // R8
    check(e_err == 1'b1, "R8", "cfg_err on illegal latency", e_err, 1);
    check(err_cmds == 0, "R8", "commands from misconfigured block", err_cmds, 0);
    check(e_done == 1'b0, "R8", "init_done with bad config", e_done, 0);
    check(cfg_err == 1'b0, "R8", "cfg_err on legal config", cfg_err, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule